// File: doc/BRIEF.md
# Temperature Limit Monitor with Alerts

This block watches offset-corrected readings from a local and a remote temperature channel, plus a fan tachometer count, and raises alarms when they leave a programmed window. Each time a channel delivers a new result strobe, a signed offset is added to the raw temperature with saturation, and the corrected value is compared against that channel's high and low limits. The fan count is compared against a single upper limit, because a larger count means a slower fan.

The block drives three active-low alarm outputs from the same evaluation:
- A comparator alert that follows the present unmasked conditions and releases by itself.
- A bus alert that is qualified by a consecutive-result fault queue and stays asserted until software clears it.
- An overtemperature output with hysteresis.

A simple register port (write strobe, read strobe, 4-bit address, 16-bit data) programs limits, offsets, masks and queue depth. The same port returns the status bits and the corrected readings.

Temperatures are signed 16-bit values with 5 fractional bits (1 LSB = 1/32 degree).

Top module: `tlm_limit_monitor`

## Requirements
- R1: Offsets are signed 8-bit values with 3 fractional bits: local at address 0, remote at address 1. Each offset is aligned to the 5-fraction-bit scale and added to its channel's raw reading on each result strobe. The sum saturates to 0x7FFF / 0x8000. The last corrected value reads back at address 13 (local) and 14 (remote).
- R2: The local limits sit at address 2 (high) and 3 (low); the remote limits sit at address 4 (high) and 5 (low). A corrected reading strictly above its high limit sets status bit 0 (local) or bit 2 (remote). A reading strictly below its low limit sets bit 1 (local) or bit 3 (remote). Equality is in limit.
- R3: A fan count strictly greater than the fan limit (address 6) sets status bit 4. The comparison is unsigned.
- R4: The comparator alert output is low from the clock after a result whose condition is out of limit and unmasked. The fault queue does not delay it. It returns high once the latest results of all unmasked conditions are in limit.
- R5: Setting a bit of the mask register (address 9, bits 4:0, same positions as status) keeps that condition off both alert outputs. The status bit still latches.
- R6: The fault queue code at address 10, bits 1:0, value N, requires N+1 consecutive out-of-limit results for a condition before its status bit latches and the bus alert can assert. Any in-limit result for that condition restarts the count.
- R7: The bus alert output stays low after a qualified unmasked event until any write to address 12. An event in the same cycle as that write keeps it low.
- R8: Reading status (address 11) returns the latched bits. The read clears each bit whose condition is absent in the latest result and keeps each bit whose condition is still present.
- R9: The overtemperature output goes low when either corrected temperature exceeds the limit at address 7. It goes high only once both are strictly below that limit minus the unsigned hysteresis at address 8. Equal to the limit does not assert.
- R10: After reset all three alarm outputs are high and the status register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loc_vld | input | 1 | New local temperature result strobe |
| loc_raw | input | 16 | Raw local temperature, signed, 5 fraction bits |
| rem_vld | input | 1 | New remote temperature result strobe |
| rem_raw | input | 16 | Raw remote temperature, signed, 5 fraction bits |
| fan_vld | input | 1 | New fan count strobe |
| fan_count | input | 16 | Tachometer count, unsigned |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the addressed register |
| cmp_alert_n | output | 1 | Self-clearing comparator alert, active low |
| bus_alert_n | output | 1 | Latched software-cleared alert, active low |
| therm_n | output | 1 | Overtemperature output with hysteresis, active low |

## Verification
The hardest state to reach is a fault queue that is partly filled and then broken. The stimulus programs a depth of three, sends two out-of-limit local results, then one in-limit result, then three more out-of-limit results. This shows that status stays clear until the sixth result.

The second hard case is a clear write that coincides with a qualifying event. One stimulus cycle drives both the clear write and the result strobe, so the set-over-clear priority of the bus alert is visible at the pin.

Read-to-clear behaviour is reached by reading status once while the condition persists, then again after an in-limit result.

// File: rtl/tlm_pkg.sv
// Shared constants for the temperature limit monitor: register map and
// status bit positions. Assumes a 4-bit register address.
package tlm_pkg;
    localparam int NCOND       = 5;
    localparam int ADR_LOC_OFS = 0;
    localparam int ADR_REM_OFS = 1;
    localparam int ADR_LOC_HI  = 2;
    localparam int ADR_LOC_LO  = 3;
    localparam int ADR_REM_HI  = 4;
    localparam int ADR_REM_LO  = 5;
    localparam int ADR_FAN_LIM = 6;
    localparam int ADR_THM_LIM = 7;
    localparam int ADR_THM_HYS = 8;
    localparam int ADR_MASK    = 9;
    localparam int ADR_QDEPTH  = 10;
    localparam int ADR_STATUS  = 11;
    localparam int ADR_ACLR    = 12;
    localparam int ADR_LOC_VAL = 13;
    localparam int ADR_REM_VAL = 14;
    // status / mask bit positions
    localparam int C_LOC_HI = 0;
    localparam int C_LOC_LO = 1;
    localparam int C_REM_HI = 2;
    localparam int C_REM_LO = 3;
    localparam int C_FAN    = 4;
endpackage

// File: rtl/tlm_offset_add.sv
// Adds a signed fixed-point offset to a signed temperature reading.
// Assumes the offset has SHIFT fewer fraction bits than the reading and
// that OW + SHIFT <= TW. The result saturates to the TW-bit signed range.
module tlm_offset_add #(
    parameter int TW    = 16,
    parameter int OW    = 8,
    parameter int SHIFT = 2
) (
    input  logic [TW-1:0] raw,
    input  logic [OW-1:0] ofs,
    output logic [TW-1:0] sum
);
    localparam int SW = TW + 1;
    localparam logic [TW-1:0] SMAX = {1'b0, {(TW-1){1'b1}}};
    localparam logic [TW-1:0] SMIN = {1'b1, {(TW-1){1'b0}}};

    logic [SW-1:0] ext_ofs;
    logic [SW-1:0] ext_raw;
    logic [SW-1:0] wide;

    // Align the offset, widen both operands by one bit, add and saturate.
    always_comb begin
        ext_ofs = {{(SW-OW){ofs[OW-1]}}, ofs} << SHIFT;
        ext_raw = {raw[TW-1], raw};
        wide    = ext_raw + ext_ofs;
        if (wide[SW-1] != wide[SW-2])
            sum = wide[SW-1] ? SMIN : SMAX;
        else
            sum = wide[TW-1:0];
    end

    // A non-negative offset never lowers the reading; a negative one never raises it.
    always_comb begin
        assert_sat_up_R1: assert (ofs[OW-1] || ($signed(sum) >= $signed(raw)));
        assert_sat_dn_R1: assert (!ofs[OW-1] || ($signed(sum) <= $signed(raw)));
    end
endmodule

// File: rtl/tlm_fault_queue.sv
// Counts consecutive out-of-limit results for one condition. The hit pulse
// fires on a strobe once depth+1 consecutive out-of-limit results have been
// seen. Assumes strobe is a single-cycle result-valid pulse.
module tlm_fault_queue #(
    parameter int QW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe,
    input  logic          cond_in,
    input  logic [QW-1:0] depth,
    output logic          hit
);
    localparam int CW = QW + 1;
    localparam logic [CW-1:0] CAP = {1'b1, {QW{1'b0}}};

    logic [CW-1:0] cnt;

    assign hit = strobe && cond_in && (cnt >= {1'b0, depth});

    // Saturating run-length counter; an in-limit result restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (strobe) begin
            if (!cond_in)
                cnt <= '0;
            else if (cnt != CAP)
                cnt <= cnt + 1'b1;
        end
    end

    assert_cnt_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CAP);
    assert_cnt_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !cond_in) |=> (cnt == '0));
endmodule

// File: rtl/tlm_therm_ctrl.sv
// Hysteretic overtemperature flag shared by both temperature channels.
// Asserts when either reading exceeds the limit; releases when both are
// below limit minus hysteresis. Assumes hysteresis is unsigned.
module tlm_therm_ctrl #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic [TW-1:0] loc_t,
    input  logic [TW-1:0] rem_t,
    input  logic [TW-1:0] limit,
    input  logic [TW-1:0] hyst,
    output logic          active
);
    logic signed [TW:0] lo_thr;
    logic               over;
    logic               under;

    // Release threshold and the two comparisons in one extra bit of range.
    always_comb begin
        lo_thr = $signed({limit[TW-1], limit}) - $signed({1'b0, hyst});
        over   = ($signed(loc_t) > $signed(limit)) || ($signed(rem_t) > $signed(limit));
        under  = ($signed({loc_t[TW-1], loc_t}) < lo_thr) &&
                 ($signed({rem_t[TW-1], rem_t}) < lo_thr);
    end

    // Set takes priority; otherwise release only below the lower threshold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active <= 1'b0;
        else if (upd) begin
            if (over)
                active <= 1'b1;
            else if (under)
                active <= 1'b0;
        end
    end

    assert_therm_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(active));
    assert_therm_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(upd));
endmodule

// File: rtl/tlm_limit_monitor.sv
// Temperature and fan limit monitor. On each result strobe it corrects the
// temperature by the channel offset and evaluates that channel's limit
// conditions. It updates fault queues, latched status, the comparator
// alert, the latched bus alert and the overtemperature output.
// Assumes result strobes are single-cycle pulses and that a register read
// is a one-cycle strobe.
module tlm_limit_monitor #(
    parameter int TW = 16,
    parameter int OW = 8,
    parameter int QW = 2,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          loc_vld,
    input  logic [TW-1:0] loc_raw,
    input  logic          rem_vld,
    input  logic [TW-1:0] rem_raw,
    input  logic          fan_vld,
    input  logic [TW-1:0] fan_count,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [TW-1:0] reg_wdata,
    output logic [TW-1:0] reg_rdata,
    output logic          cmp_alert_n,
    output logic          bus_alert_n,
    output logic          therm_n
);
    import tlm_pkg::*;

    localparam int SHIFT = 2;
    localparam logic [TW-1:0] SMAX = {1'b0, {(TW-1){1'b1}}};
    localparam logic [TW-1:0] SMIN = {1'b1, {(TW-1){1'b0}}};

    logic [OW-1:0]    ofs_loc, ofs_rem;
    logic [TW-1:0]    lim_lh, lim_ll, lim_rh, lim_rl, lim_fan, thm_lim, thm_hys;
    logic [NCOND-1:0] mask;
    logic [QW-1:0]    qdepth;
    logic [TW-1:0]    loc_c, rem_c, loc_t, rem_t, loc_nxt, rem_nxt;
    logic [NCOND-1:0] cond, cond_new, strobe, hit, status;
    logic             bus_flag, therm_active, stat_rd, clr_wr;

    // Offset correction for both temperature channels.
    tlm_offset_add #(.TW(TW), .OW(OW), .SHIFT(SHIFT)) u_ofs_loc (
        .raw(loc_raw), .ofs(ofs_loc), .sum(loc_c));
    tlm_offset_add #(.TW(TW), .OW(OW), .SHIFT(SHIFT)) u_ofs_rem (
        .raw(rem_raw), .ofs(ofs_rem), .sum(rem_c));

    // Per-condition evaluation of the incoming result and its strobe.
    always_comb begin
        cond_new[C_LOC_HI] = $signed(loc_c) > $signed(lim_lh);
        cond_new[C_LOC_LO] = $signed(loc_c) < $signed(lim_ll);
        cond_new[C_REM_HI] = $signed(rem_c) > $signed(lim_rh);
        cond_new[C_REM_LO] = $signed(rem_c) < $signed(lim_rl);
        cond_new[C_FAN]    = fan_count > lim_fan;
        strobe = {fan_vld, rem_vld, rem_vld, loc_vld, loc_vld};
        stat_rd = reg_rd && (reg_addr == AW'(ADR_STATUS));
        clr_wr  = reg_wr && (reg_addr == AW'(ADR_ACLR));
        loc_nxt = loc_vld ? loc_c : loc_t;
        rem_nxt = rem_vld ? rem_c : rem_t;
    end

    // Register file writes; reset loads limits that never trip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_loc <= '0;   ofs_rem <= '0;
            lim_lh  <= SMAX; lim_ll  <= SMIN;
            lim_rh  <= SMAX; lim_rl  <= SMIN;
            lim_fan <= '1;   thm_lim <= SMAX; thm_hys <= '0;
            mask    <= '0;   qdepth  <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                AW'(ADR_LOC_OFS): ofs_loc <= reg_wdata[OW-1:0];
                AW'(ADR_REM_OFS): ofs_rem <= reg_wdata[OW-1:0];
                AW'(ADR_LOC_HI):  lim_lh  <= reg_wdata;
                AW'(ADR_LOC_LO):  lim_ll  <= reg_wdata;
                AW'(ADR_REM_HI):  lim_rh  <= reg_wdata;
                AW'(ADR_REM_LO):  lim_rl  <= reg_wdata;
                AW'(ADR_FAN_LIM): lim_fan <= reg_wdata;
                AW'(ADR_THM_LIM): thm_lim <= reg_wdata;
                AW'(ADR_THM_HYS): thm_hys <= reg_wdata;
                AW'(ADR_MASK):    mask    <= reg_wdata[NCOND-1:0];
                AW'(ADR_QDEPTH):  qdepth  <= reg_wdata[QW-1:0];
                default: ;
            endcase
        end
    end

    // Latest corrected readings and latest per-condition result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_t <= '0;
            rem_t <= '0;
            cond  <= '0;
        end else begin
            loc_t <= loc_nxt;
            rem_t <= rem_nxt;
            for (int i = 0; i < NCOND; i++)
                if (strobe[i]) cond[i] <= cond_new[i];
        end
    end

    // One fault queue per condition.
    for (genvar g = 0; g < NCOND; g++) begin : g_queue
        tlm_fault_queue #(.QW(QW)) u_fq (
            .clk(clk), .rst_n(rst_n), .strobe(strobe[g]),
            .cond_in(cond_new[g]), .depth(qdepth), .hit(hit[g]));
    end

    // Latched status: a qualified hit sets; a status read clears vanished conditions.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= '0;
        else
            for (int i = 0; i < NCOND; i++)
                if (hit[i])
                    status[i] <= 1'b1;
                else if (stat_rd && !cond[i])
                    status[i] <= 1'b0;
    end

    // Bus alert latch: an unmasked qualified hit sets, a clear write releases.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_flag <= 1'b0;
        else if (|(hit & ~mask))
            bus_flag <= 1'b1;
        else if (clr_wr)
            bus_flag <= 1'b0;
    end

    tlm_therm_ctrl #(.TW(TW)) u_therm (
        .clk(clk), .rst_n(rst_n), .upd(loc_vld || rem_vld),
        .loc_t(loc_nxt), .rem_t(rem_nxt), .limit(thm_lim), .hyst(thm_hys),
        .active(therm_active));

    assign cmp_alert_n = ~|(cond & ~mask);
    assign bus_alert_n = ~bus_flag;
    assign therm_n     = ~therm_active;

    // Read data multiplexer.
    always_comb begin
        case (reg_addr)
            AW'(ADR_LOC_OFS): reg_rdata = {{(TW-OW){ofs_loc[OW-1]}}, ofs_loc};
            AW'(ADR_REM_OFS): reg_rdata = {{(TW-OW){ofs_rem[OW-1]}}, ofs_rem};
            AW'(ADR_LOC_HI):  reg_rdata = lim_lh;
            AW'(ADR_LOC_LO):  reg_rdata = lim_ll;
            AW'(ADR_REM_HI):  reg_rdata = lim_rh;
            AW'(ADR_REM_LO):  reg_rdata = lim_rl;
            AW'(ADR_FAN_LIM): reg_rdata = lim_fan;
            AW'(ADR_THM_LIM): reg_rdata = thm_lim;
            AW'(ADR_THM_HYS): reg_rdata = thm_hys;
            AW'(ADR_MASK):    reg_rdata = {{(TW-NCOND){1'b0}}, mask};
            AW'(ADR_QDEPTH):  reg_rdata = {{(TW-QW){1'b0}}, qdepth};
            AW'(ADR_STATUS):  reg_rdata = {{(TW-NCOND){1'b0}}, status};
            AW'(ADR_LOC_VAL): reg_rdata = loc_t;
            AW'(ADR_REM_VAL): reg_rdata = rem_t;
            default:          reg_rdata = '0;
        endcase
    end

    assert_bus_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_flag && !clr_wr) |=> bus_flag);
    assert_mask_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_flag && ((hit & ~mask) == '0)) |=> !bus_flag);
    assert_cmp_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!loc_vld && !rem_vld && !fan_vld && !reg_wr) |=> $stable(cmp_alert_n));
    assert_status_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == '0 && !stat_rd) |=> $stable(status));
endmodule

// File: tb/tlm_limit_monitor_bench.sv
module tlm_limit_monitor_bench;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        loc_vld = 1'b0, rem_vld = 1'b0, fan_vld = 1'b0;
    logic [15:0] loc_raw = '0, rem_raw = '0, fan_count = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        cmp_alert_n, bus_alert_n, therm_n;

    int n_chk = 0;
    int n_err = 0;

    tlm_limit_monitor u_tlm_limit_monitor (
        .clk(clk), .rst_n(rst_n),
        .loc_vld(loc_vld), .loc_raw(loc_raw),
        .rem_vld(rem_vld), .rem_raw(rem_raw),
        .fan_vld(fan_vld), .fan_count(fan_count),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmp_alert_n(cmp_alert_n), .bus_alert_n(bus_alert_n), .therm_n(therm_n));

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 4'(a);
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic push_loc(input logic [15:0] v);
        @(negedge clk);
        loc_vld = 1'b1; loc_raw = v;
        @(negedge clk);
        loc_vld = 1'b0;
    endtask

    task automatic push_rem(input logic [15:0] v);
        @(negedge clk);
        rem_vld = 1'b1; rem_raw = v;
        @(negedge clk);
        rem_vld = 1'b0;
    endtask

    task automatic push_fan(input logic [15:0] v);
        @(negedge clk);
        fan_vld = 1'b1; fan_count = v;
        @(negedge clk);
        fan_vld = 1'b0;
    endtask

    // R10: outputs inactive and status empty after reset
    task automatic t_reset();
        logic [15:0] d;
        do_reset();
        check("R10 cmp", cmp_alert_n, 1);
        check("R10 bus", bus_alert_n, 1);
        check("R10 therm", therm_n, 1);
        rd(11, d);
        check("R10 status", d, 0);
    endtask

    // R1: offset addition and saturation
    task automatic t_offset();
        logic [15:0] d;
        do_reset();
        wr(0, 16'h000C);              // +1.5 degrees
        push_loc(16'd800);
        rd(13, d);
        check("R1 local +1.5", d, 16'd848);
        wr(1, 16'h00F0);              // -2.0 degrees
        push_rem(16'd100);
        rd(14, d);
        check("R1 remote -2.0", d, 16'd36);
        wr(0, 16'h007F);              // +15.875 degrees
        push_loc(16'h7F00);
        rd(13, d);
        check("R1 saturate high", d, 16'h7FFF);
        wr(1, 16'h0080);              // -16 degrees
        push_rem(16'h8100);
        rd(14, d);
        check("R1 saturate low", d, 16'h8000);
    endtask

    // R2, R4, R7, R8: limit trip, comparator follow, latch and read-clear
    task automatic t_limits();
        logic [15:0] d;
        do_reset();
        wr(2, 16'd800);
        wr(3, 16'd0);
        push_loc(16'd801);
        check("R4 cmp low on trip", cmp_alert_n, 0);
        check("R7 bus low on trip", bus_alert_n, 0);
        rd(11, d);
        check("R2 local high bit", d, 16'h0001);
        push_loc(16'd800);
        check("R4 cmp released at equal", cmp_alert_n, 1);
        check("R7 bus held", bus_alert_n, 0);
        rd(11, d);
        check("R8 still latched", d, 16'h0001);
        rd(11, d);
        check("R8 cleared by read", d, 16'h0000);
        wr(12, 16'h0000);
        check("R7 bus cleared", bus_alert_n, 1);
        push_loc(16'hFFFF);
        rd(11, d);
        check("R2 local low bit", d, 16'h0002);
    endtask

    // R3: fan count over limit
    task automatic t_fan();
        logic [15:0] d;
        do_reset();
        wr(6, 16'd1000);
        push_fan(16'd1000);
        check("R3 equal count no alert", cmp_alert_n, 1);
        push_fan(16'd1001);
        check("R3 over count alert", cmp_alert_n, 0);
        rd(11, d);
        check("R3 fan bit", d, 16'h0010);
    endtask

    // R5: masked condition latches status but raises no alert
    task automatic t_mask();
        logic [15:0] d;
        do_reset();
        wr(9, 16'h0004);
        wr(4, 16'd800);
        push_rem(16'd900);
        check("R5 cmp masked", cmp_alert_n, 1);
        check("R5 bus masked", bus_alert_n, 1);
        rd(11, d);
        check("R5 status still set", d, 16'h0004);
    endtask

    // R6: fault queue of depth 3 with an interrupted run
    task automatic t_queue();
        logic [15:0] d;
        do_reset();
        wr(10, 16'd2);
        wr(2, 16'd800);
        push_loc(16'd900);
        check("R4 cmp unqualified", cmp_alert_n, 0);
        push_loc(16'd900);
        check("R6 bus waits", bus_alert_n, 1);
        push_loc(16'd700);
        push_loc(16'd900);
        push_loc(16'd900);
        rd(11, d);
        check("R6 run restarted", d, 16'h0000);
        check("R6 bus still idle", bus_alert_n, 1);
        push_loc(16'd900);
        rd(11, d);
        check("R6 third result latches", d, 16'h0001);
        check("R6 bus asserted", bus_alert_n, 0);
    endtask

    // R7: set wins over a simultaneous clear
    task automatic t_set_wins();
        do_reset();
        wr(2, 16'd800);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'd12; reg_wdata = '0;
        loc_vld = 1'b1; loc_raw = 16'd900;
        @(negedge clk);
        reg_wr = 1'b0; loc_vld = 1'b0;
        check("R7 set beats clear", bus_alert_n, 0);
        wr(12, 16'h0000);
        check("R7 clear alone", bus_alert_n, 1);
    endtask

    // R9: overtemperature with hysteresis across both channels
    task automatic t_therm();
        do_reset();
        wr(7, 16'd2560);
        wr(8, 16'd160);
        push_loc(16'd2560);
        check("R9 equal no assert", therm_n, 1);
        push_loc(16'd2561);
        check("R9 assert above", therm_n, 0);
        push_loc(16'd2500);
        check("R9 hold in band", therm_n, 0);
        push_rem(16'd2300);
        check("R9 hold local in band", therm_n, 0);
        push_loc(16'd2400);
        check("R9 hold at threshold", therm_n, 0);
        push_loc(16'd2399);
        check("R9 release below", therm_n, 1);
        push_rem(16'd2600);
        check("R9 remote asserts", therm_n, 0);
    endtask

    initial begin
        #(PERIOD * 100000);
        n_err++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset();
        t_offset();
        t_limits();
        t_fan();
        t_mask();
        t_queue();
        t_set_wins();
        t_therm();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end
endmodule